// File: doc/BRIEF.md
# Scanline Compare Interrupt Unit

This unit counts the visible lines of a video frame and raises an interrupt when a line chosen by software has been reached. A timing monitor elsewhere in the chip supplies a single-cycle pulse for each line, together with that line's number. A pulse whose line number is below the visible limit advances an 8-bit line counter and marks the frame as active. A run of pulses for non-visible lines tells the unit that the frame has ended, so it rewinds itself without any help from software.

Software programs a target line and an enable bit through two byte-wide registers on the CPU bus. When the counter reaches the target, a pending flag is latched. The interrupt output is high only while the enable, the pending flag and the in-frame flag are all set. Reading the status register returns both flags and acknowledges the pending one.

Top module: `scanline_irq`

## Requirements
- R1: After reset the status register reads 0x00 and `irq` is low.
- R2: A write to the target-line address stores the full 8-bit data. The pending flag sets on the clock edge of the visible pulse that brings the counter to the target value.
- R3: A target value of zero never sets the pending flag.
- R4: A status read returns the pending flag in bit 7 and the in-frame flag in bit 6, with bits 5..0 zero. The read clears the pending flag at the clock edge that ends the read cycle.
- R5: A pulse with `line_num` below VISIBLE_LINES (line VISIBLE_LINES-1 included) increments the counter and sets the in-frame flag.
- R6: IDLE_PULSES consecutive pulses with `line_num` at or above VISIBLE_LINES reset the counter to zero and clear both flags. A shorter run changes neither flag.
- R7: A write to the status address loads the enable from data bit 7 only. `irq` is high exactly when the enable, pending and in-frame flags are all set.
- R8: Changing the enable does not alter a pending flag that is already set.
- R9: When a matching pulse and a status read fall in the same cycle, the read returns the earlier flags and the pending flag ends up set.
- R10: After an idle reset, counting restarts from zero, so the next frame matches the same target again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Status byte while the status address is read, else zero |
| line_pulse | input | 1 | One-cycle pulse for each scanline |
| line_num | input | LINE_W | Line number qualifying the pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the unit with VISIBLE_LINES set to 16 and IDLE_PULSES left at 3. A short frame lets the test reach the last visible line, the first non-visible line and a complete idle rewind within a few dozen cycles. At that scale it can try target zero, a match on line 15, a run of idle pulses one short of the limit, and a match that lands in the same cycle as an acknowledging read. The register addresses keep their defaults.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LINE_REG_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] STAT_REG_ADDR = 16'h5204,
  parameter int LINE_W = 9,
  parameter int VISIBLE_LINES = 240,
  parameter int IDLE_PULSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              line_pulse,
  input  logic [LINE_W-1:0] line_num,
  output logic              irq
);
  localparam int IDLE_W = $clog2(IDLE_PULSES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_PULSES - 1);
  localparam logic [LINE_W-1:0] VIS_LIM = LINE_W'(VISIBLE_LINES);

  logic [7:0]        target_q, count_q;
  logic              en_q, pend_q, frame_q;
  logic [IDLE_W-1:0] idle_q;

  wire        wr_line   = cpu_wr && (cpu_addr == LINE_REG_ADDR);
  wire        wr_stat   = cpu_wr && (cpu_addr == STAT_REG_ADDR);
  wire        rd_stat   = cpu_rd && (cpu_addr == STAT_REG_ADDR);
  wire        visible   = line_pulse && (line_num < VIS_LIM);
  wire        blank     = line_pulse && !(line_num < VIS_LIM);
  wire [7:0]  count_nx  = count_q + 8'd1;
  wire        hit       = visible && (target_q != 8'd0) && (count_nx == target_q);
  wire        idle_done = blank && (idle_q == IDLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      count_q  <= '0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      frame_q  <= 1'b0;
      idle_q   <= '0;
    end else begin
      if (wr_line) target_q <= cpu_wdata;
      if (wr_stat) en_q <= cpu_wdata[7];

      if (visible) begin
        count_q <= count_nx;
        frame_q <= 1'b1;
        idle_q  <= '0;
      end else if (idle_done) begin
        count_q <= '0;
        frame_q <= 1'b0;
        idle_q  <= '0;
      end else if (blank) begin
        idle_q  <= idle_q + 1'b1;
      end

      if (hit)                     pend_q <= 1'b1;
      else if (idle_done || rd_stat) pend_q <= 1'b0;
    end
  end

  assign cpu_rdata = rd_stat ? {pend_q, frame_q, 6'b0} : 8'h00;
  assign irq       = en_q && pend_q && frame_q;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int LINE_W = 9,
  parameter int VISIBLE_LINES = 240,
  parameter int IDLE_PULSES = 3,
  parameter int IDLE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stat_rd,
  input logic              line_pulse,
  input logic [LINE_W-1:0] line_num,
  input logic [7:0]        target,
  input logic [7:0]        count,
  input logic [IDLE_W-1:0] idle,
  input logic              en,
  input logic              pend,
  input logic              frame,
  input logic              irq
);
  logic vis;
  assign vis = line_pulse && (line_num < LINE_W'(VISIBLE_LINES));

  assert_pend_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(vis));
  assert_zero_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && target == 8'd0 && !pend) |=> !pend);
  assert_read_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !vis) |=> !pend);
  assert_frame_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vis |=> frame);
  assert_idle_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && !vis && idle == IDLE_W'(IDLE_PULSES - 1)) |=> (!pend && !frame && count == 8'd0));
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && frame));
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !stat_rd && !(line_pulse && !vis)) |=> pend);
endmodule

bind scanline_irq scanline_irq_chk #(
  .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES),
  .IDLE_PULSES(IDLE_PULSES), .IDLE_W(IDLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(rd_stat),
  .line_pulse(line_pulse), .line_num(line_num),
  .target(target_q), .count(count_q), .idle(idle_q),
  .en(en_q), .pend(pend_q), .frame(frame_q), .irq(irq)
);

// File: tb/sim_scanline_irq.sv
module sim_scanline_irq;
  localparam logic [15:0] A_LINE = 16'h5203;
  localparam logic [15:0] A_STAT = 16'h5204;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        line_pulse = 1'b0;
  logic [8:0]  line_num = '0;
  logic        irq;
  logic        probe = 1'b0;

  int n_tests = 0, n_fail = 0;

  typedef struct {
    logic       chk_stat;
    logic [7:0] stat;
    logic       irq;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  scanline_irq #(.VISIBLE_LINES(16), .IDLE_PULSES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .line_pulse(line_pulse), .line_num(line_num), .irq(irq));

  always begin
    @(negedge clk);
    #1;
    if (cpu_rd || probe) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard empty: actual stat=%h irq=%b expected an item", cpu_rdata, irq);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if ((it.chk_stat && cpu_rdata !== it.stat) || irq !== it.irq) begin
          n_fail++;
          $display("FAIL %s: actual stat=%h irq=%b expected stat=%h irq=%b",
                   it.tag, cpu_rdata, irq, it.stat, it.irq);
        end
      end
    end
  end

  task automatic clear_bus();
    cpu_wr = 1'b0; cpu_rd = 1'b0; line_pulse = 1'b0; probe = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); clear_bus();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); clear_bus();
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
  endtask

  task automatic pulse(input int ln);
    @(negedge clk); clear_bus();
    line_num = 9'(ln); line_pulse = 1'b1;
  endtask

  task automatic rd(input logic [7:0] es, input logic ei, input string tag);
    item_t it;
    it.chk_stat = 1'b1; it.stat = es; it.irq = ei; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); clear_bus();
    cpu_addr = A_STAT; cpu_rd = 1'b1;
  endtask

  task automatic pulse_rd(input int ln, input logic [7:0] es, input logic ei, input string tag);
    item_t it;
    it.chk_stat = 1'b1; it.stat = es; it.irq = ei; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); clear_bus();
    cpu_addr = A_STAT; cpu_rd = 1'b1;
    line_num = 9'(ln); line_pulse = 1'b1;
  endtask

  task automatic chk_irq(input logic ei, input string tag);
    item_t it;
    it.chk_stat = 1'b0; it.stat = 8'h00; it.irq = ei; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); clear_bus();
    probe = 1'b1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #20000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, 1'b0, "R1 reset state");

    wr(A_LINE, 8'd3); wr(A_STAT, 8'h80);
    pulse(0); pulse(1);
    rd(8'h40, 1'b0, "R5 in-frame after visible pulses");
    pulse(2);
    rd(8'hC0, 1'b1, "R2 R7 match on third line");
    rd(8'h40, 1'b0, "R4 read acknowledged pending");

    pulse(16); pulse(16);
    rd(8'h40, 1'b0, "R6 short idle run keeps flags");
    pulse(20);
    rd(8'h00, 1'b0, "R6 idle rewind clears flags");

    pulse(0); pulse(1); pulse(2);
    wr(A_STAT, 8'h00);
    chk_irq(1'b0, "R7 disabled masks irq");
    wr(A_STAT, 8'h80);
    chk_irq(1'b1, "R8 pending kept across enable change");
    wr(A_STAT, 8'h7F);
    chk_irq(1'b0, "R7 only bit 7 enables");
    wr(A_STAT, 8'h80);
    pulse(16); pulse(16); pulse(16);
    rd(8'h00, 1'b0, "R6 rewind clears pending");

    wr(A_LINE, 8'd1);
    pulse(15);
    rd(8'hC0, 1'b1, "R5 R10 last visible line counts from zero");
    pulse(200); pulse(200); pulse(200);

    wr(A_LINE, 8'd0);
    pulse(0); pulse(1); pulse(2); pulse(3); pulse(4);
    rd(8'h40, 1'b0, "R3 zero target never matches");
    pulse(16); pulse(16); pulse(16);

    wr(A_LINE, 8'd2);
    pulse(0);
    pulse_rd(1, 8'h40, 1'b0, "R9 read in match cycle sees old flags");
    rd(8'hC0, 1'b1, "R9 match wins over read clear");
    idle(); idle();
    if (sb.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard leftover: actual %0d items expected 0", sb.size());
    end
    finish_run();
  end
endmodule